// File: doc/BRIEF.md
# Carrier-Gated Asynchronous Serial Receiver

This block receives asynchronous characters from a serial line. A clock enable, `sample_en`, sets the pace of the receiver. Each pulse of `sample_en` is one receive-clock rising edge. That clock runs at one, sixteen or sixty-four times the bit rate, as `rate_sel` chooses. The line idles at the high (mark) level. A character starts with a low (space) start bit, carries 5 to 8 data bits with the least significant bit first, and ends with one stop bit.

At the oversampled rates, the receiver checks a falling edge again half a bit later before it accepts a start bit. After that it samples each bit at its centre. A finished character goes into a holding register, and a ready flag tells the CPU to read it. The receiver only advances while the active-low carrier input is low and the enable input is high. Losing carrier freezes the receiver exactly where it is. Disabling the receiver resets it and drops the ready flag. The serial input and the carrier input each pass through two synchronizing flops before use.

Top module: `async_rx`

## Requirements
- R1: With `rate_sel`=1 (16 ticks per bit), a character on `rxd_in` appears correctly on `rx_data` and `rx_ready` goes high.
- R2: With `rate_sel`=2 (64 ticks per bit; the value 3 also selects 64), characters are received correctly.
- R3: With `rate_sel`=0 (one tick per bit), the line is sampled once per tick. The first low sample is taken as the start bit, and each following tick samples the next bit.
- R4: `len_sel` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits arrive LSB first and are right-aligned in `rx_data`. Unused upper bits read as zero.
- R5: At 16X and 64X, a low level that is gone by the middle of the start bit is discarded. No character results, and a following character is received correctly.
- R6: `frame_err` takes the inverse of the stop-bit sample of each completed character. It is 1 for a low stop bit and 0 for a high one.
- R7: `rx_ready` rises the cycle after a character completes. A one-cycle `rd_strobe` clears it on the next clock edge.
- R8: If a character completes while `rx_ready` is still high, `overrun` goes high and `rx_data` takes the new character. `rd_strobe` clears `overrun`.
- R9: While the synchronized `carrier_n` is high, ticks are ignored and the receiver state holds. Reception resumes where it stopped once `carrier_n` returns low.
- R10: While `rx_en` is low, `rx_ready` and `overrun` clear, the receiver returns to idle, and characters on the line are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Receive-clock tick, one cycle wide |
| rate_sel | input | 2 | Ticks per bit: 0 = 1, 1 = 16, 2 or 3 = 64 |
| len_sel | input | 2 | Data bits: 0..3 select 5..8 |
| rx_en | input | 1 | Receiver enable |
| rxd_in | input | 1 | Serial data; high is mark |
| carrier_n | input | 1 | Active-low carrier detect |
| rd_strobe | input | 1 | CPU read of the holding register |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Character waiting |
| overrun | output | 1 | Character replaced before it was read |
| frame_err | output | 1 | Last character had a low stop bit |

## Verification
The assertions assume that `rate_sel` and `len_sel` hold still during a character, and that `rd_strobe` comes as a single-cycle pulse. The stimulus sets both mode inputs only between characters. It changes `rxd_in` and `carrier_n` only on falling clock edges, and then allows three cycles before the next tick so the synchronizers have settled. It follows every character with a full idle bit, so a low stop bit cannot leave the receiver partway through a false start.

// File: rtl/async_rx.sv
module async_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_en,
  input  logic [1:0] rate_sel,
  input  logic [1:0] len_sel,
  input  logic       rx_en,
  input  logic       rxd_in,
  input  logic       carrier_n,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       overrun,
  output logic       frame_err
);
  typedef enum logic [1:0] {IDLE, START, DATA, STOP} st_t;

  logic [1:0] rxd_sync, dcd_sync;
  st_t        state;
  logic [5:0] cnt;
  logic [2:0] idx;
  logic [7:0] shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxd_sync <= 2'b11;
      dcd_sync <= 2'b11;
    end else begin
      rxd_sync <= {rxd_sync[0], rxd_in};
      dcd_sync <= {dcd_sync[0], carrier_n};
    end

  wire       rxd_q        = rxd_sync[1];
  wire       carrier_lost = dcd_sync[1];
  wire       tick         = sample_en & rx_en & ~carrier_lost;
  wire [5:0] last_cnt     = (rate_sel == 2'd0) ? 6'd0 : (rate_sel == 2'd1) ? 6'd15 : 6'd63;
  wire [5:0] half_cnt     = (rate_sel == 2'd1) ? 6'd7 : 6'd31;
  wire [2:0] last_bit     = 3'd4 + {1'b0, len_sel};
  wire       char_done    = tick && (state == STOP) && (cnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
    end else if (!rx_en) begin
      state <= IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else if (tick) begin
      case (state)
        IDLE:
          if (!rxd_q) begin
            shreg <= '0;
            idx   <= '0;
            cnt   <= '0;
            state <= (rate_sel == 2'd0) ? DATA : START;
          end
        START:
          if (cnt == half_cnt) begin
            cnt   <= '0;
            state <= rxd_q ? IDLE : DATA;
          end else cnt <= cnt + 6'd1;
        DATA:
          if (cnt == last_cnt) begin
            cnt        <= '0;
            shreg[idx] <= rxd_q;
            if (idx == last_bit) state <= STOP;
            else idx <= idx + 3'd1;
          end else cnt <= cnt + 6'd1;
        default:
          if (cnt == last_cnt) begin
            cnt   <= '0;
            state <= IDLE;
          end else cnt <= cnt + 6'd1;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data   <= '0;
      frame_err <= 1'b0;
    end else if (char_done) begin
      rx_data   <= shreg;
      frame_err <= ~rxd_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_ready <= 1'b0;
      overrun  <= 1'b0;
    end else if (!rx_en) begin
      rx_ready <= 1'b0;
      overrun  <= 1'b0;
    end else if (char_done) begin
      rx_ready <= 1'b1;
      overrun  <= rx_ready & ~rd_strobe;
    end else if (rd_strobe) begin
      rx_ready <= 1'b0;
      overrun  <= 1'b0;
    end
endmodule

module async_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       rd_strobe,
  input logic       rx_ready,
  input logic       overrun,
  input logic [7:0] rx_data,
  input logic       char_done,
  input logic       carrier_lost,
  input logic [1:0] state_q,
  input logic [5:0] cnt_q
);
  // R7
  read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rx_en && !char_done) |=> !rx_ready);

  // R8
  read_clears_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !overrun);

  // R8
  overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_ready));

  // R9
  carrier_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_lost && rx_en) |=> ($stable(state_q) && $stable(cnt_q)));

  // R10
  disable_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_ready && !overrun));

  // R1
  data_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !char_done |=> $stable(rx_data));
endmodule

bind async_rx async_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_strobe(rd_strobe),
  .rx_ready(rx_ready), .overrun(overrun), .rx_data(rx_data),
  .char_done(char_done), .carrier_lost(carrier_lost),
  .state_q(state), .cnt_q(cnt)
);

// File: tb/async_rx_bench.sv
module async_rx_bench;
  logic clk = 0, rst_n = 0;
  logic sample_en = 0, rx_en = 0, rxd_in = 1, carrier_n = 0, rd_strobe = 0;
  logic [1:0] rate_sel = 1, len_sel = 3;
  logic [7:0] rx_data;
  logic rx_ready, overrun, frame_err;
  int checks = 0, fails = 0;
  int tpb = 16;
  bit finished = 0;

  always #2.5 clk = ~clk;

  async_rx u_async_rx (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tk();
    @(negedge clk) sample_en = 1;
    @(negedge clk) sample_en = 0;
  endtask

  task automatic put_bit(input logic v, input int n);
    rxd_in = v;
    repeat (3) @(negedge clk);
    repeat (n) tk();
  endtask

  task automatic pause_carrier(input logic v);
    carrier_n = 1;
    repeat (3) @(negedge clk);
    rxd_in = ~v;
    repeat (3) @(negedge clk);
    repeat (40) tk();
    rxd_in = v;
    chk("R9 no completion while carrier lost", rx_ready, 0);
    carrier_n = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input int nbits, input logic [7:0] val, input logic stopv, input int pause_at);
    put_bit(0, tpb);
    for (int i = 0; i < nbits; i++) begin
      put_bit(val[i], tpb);
      if (i == pause_at) pause_carrier(val[i]);
    end
    put_bit(stopv, tpb);
    put_bit(1, tpb);
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1;
    @(negedge clk) rd_strobe = 0;
  endtask

  task automatic set_mode(input logic [1:0] r, input logic [1:0] l);
    rate_sel = r; len_sel = l;
    tpb = (r == 0) ? 1 : (r == 1) ? 16 : 64;
  endtask

  task automatic t_reset();
    chk("reset rx_ready", rx_ready, 0);
    chk("reset overrun", overrun, 0);
    chk("reset frame_err", frame_err, 0);
  endtask

  task automatic t_16x();
    set_mode(1, 3);
    send(8, 8'hA5, 1, -1);
    chk("R1 data 16X", rx_data, 8'hA5);
    chk("R7 ready after char", rx_ready, 1);
    chk("R6 good stop", frame_err, 0);
    do_read();
    chk("R7 read clears ready", rx_ready, 0);
  endtask

  task automatic t_64x();
    set_mode(2, 2);
    send(7, 8'h35, 1, -1);
    chk("R2 R4 data 64X 7 bits", rx_data, 8'h35);
    do_read();
    set_mode(3, 3);
    send(8, 8'hC3, 1, -1);
    chk("R2 rate_sel 3 as 64X", rx_data, 8'hC3);
    do_read();
  endtask

  task automatic t_1x();
    set_mode(0, 0);
    send(5, 8'h13, 1, -1);
    chk("R3 R4 data 1X 5 bits", rx_data, 8'h13);
    chk("R3 ready 1X", rx_ready, 1);
    do_read();
    set_mode(0, 1);
    send(6, 8'hFF, 1, -1);
    chk("R4 6 bits upper zero", rx_data, 8'h3F);
    do_read();
  endtask

  task automatic t_glitch();
    set_mode(1, 3);
    rxd_in = 0;
    repeat (3) @(negedge clk);
    repeat (3) tk();
    put_bit(1, 40);
    chk("R5 glitch rejected", rx_ready, 0);
    send(8, 8'h6E, 1, -1);
    chk("R5 next char after glitch", rx_data, 8'h6E);
    do_read();
  endtask

  task automatic t_frame();
    set_mode(1, 3);
    send(8, 8'h81, 0, -1);
    chk("R6 low stop sets frame_err", frame_err, 1);
    chk("R6 data still loaded", rx_data, 8'h81);
    do_read();
    send(8, 8'h42, 1, -1);
    chk("R6 good stop clears frame_err", frame_err, 0);
    do_read();
  endtask

  task automatic t_overrun();
    set_mode(1, 3);
    send(8, 8'h11, 1, -1);
    chk("R8 no overrun first", overrun, 0);
    send(8, 8'h22, 1, -1);
    chk("R8 overrun set", overrun, 1);
    chk("R8 newer data kept", rx_data, 8'h22);
    do_read();
    chk("R8 read clears overrun", overrun, 0);
    chk("R8 read clears ready", rx_ready, 0);
  endtask

  task automatic t_carrier();
    set_mode(1, 3);
    send(8, 8'h9C, 1, 2);
    chk("R9 char intact after carrier pause", rx_data, 8'h9C);
    chk("R9 ready after resume", rx_ready, 1);
    do_read();
  endtask

  task automatic t_disable();
    set_mode(1, 3);
    send(8, 8'h5D, 1, -1);
    send(8, 8'h5E, 1, -1);
    @(negedge clk) rx_en = 0;
    @(negedge clk);
    chk("R10 disable clears ready", rx_ready, 0);
    chk("R10 disable clears overrun", overrun, 0);
    send(8, 8'h77, 1, -1);
    chk("R10 char ignored while disabled", rx_ready, 0);
    chk("R10 data unchanged while disabled", rx_data, 8'h5E);
    @(negedge clk) rx_en = 1;
    send(8, 8'h3A, 1, -1);
    chk("R10 works after re-enable", rx_data, 8'h3A);
    do_read();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    rx_en = 1;
    repeat (2) @(negedge clk);
    t_16x();
    t_64x();
    t_1x();
    t_glitch();
    t_frame();
    t_overrun();
    t_carrier();
    t_disable();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule